// File: doc/BRIEF.md
# Adaptive Row-Activation Counter Tree

This block watches the row activations of one DRAM bank and tells the controller when a group of rows has been opened often enough that its physical neighbours need an early refresh. It has a small pool of activation counters. At the start of each refresh interval a single counter covers the whole bank. A counter whose count reaches the split threshold of its tree level hands the upper half of its row range to a newly activated counter. The new counter starts from the same count. Rows that are opened often therefore end up in small groups, and rarely used rows stay in large ones.

A counter that reaches the refresh threshold `RFSH_THR` is cleared. The block then emits a one-cycle refresh request that covers the counter's range widened by one row on each side, clamped to the bank. The split threshold of level `l` is `RFSH_THR*(l+1)/LEVELS`, and the last level uses `RFSH_THR` itself. Splitting stops at level `LEVELS-1` or when every counter is in use. From then on, affected counters simply count up to `RFSH_THR`.

Top module: `hot_row_tree`

## Requirements
- R1: After reset, or in the cycle after `start_i` is sampled high, only one counter is active, it covers rows 0 to 2^ROW_W-1 at level 0 with a count of 0, and no refresh is requested. An activation sampled together with `start_i` is discarded.
- R2: Every row belongs to exactly one active counter at all times. An activation sampled with `act_i` high and `start_i` low adds one to that counter.
- R3: When a counter at level l below LEVELS-1 reaches `RFSH_THR*(l+1)/LEVELS` and a free counter exists, the counter splits. It keeps the lower half of its range, a free counter takes the upper half, both carry the reached count, and both move to level l+1.
- R4: A counter that reaches its split threshold while the pool is full does not split. It keeps counting and requests a refresh only on reaching `RFSH_THR`.
- R5: When an activation brings a counter to `RFSH_THR`, that counter returns to 0. `rfsh_o` is high for exactly the one cycle that follows the clock edge sampling that activation.
- R6: With a refresh, `rfsh_lo_o` is the counter's lower bound minus 1, but not below 0. `rfsh_hi_o` is its upper bound plus 1, but not above 2^ROW_W-1.
- R7: No counter goes beyond level LEVELS-1, so no group is smaller than 2^ROW_W/2^(LEVELS-1) rows. A counter at the last level counts straight to `RFSH_THR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of a refresh interval; rebuilds the initial tree |
| act_i | input | 1 | Row activation strobe |
| row_i | input | ROW_W | Row address of the activation |
| rfsh_o | output | 1 | Refresh request pulse |
| rfsh_lo_o | output | ROW_W | Lowest row to refresh |
| rfsh_hi_o | output | ROW_W | Highest row to refresh |

## Verification
Single-row hammering at the bottom edge, the top edge and the middle of the bank separates the split ladder and the clamped refresh window from the unclamped one. A hammer that is held together with interval start shows whether counting is blocked during a rebuild. A sequence that fills the pool while one counter is still at a shallow level tells R4 apart from R3. Biased random traffic, with a few hot rows over a random background and occasional interval starts, is compared against a behavioural tree model on every cycle. This catches wrong split halves, wrong free-slot use and wrong counts after splits.

// File: rtl/hot_row_pkg.sv
package hot_row_pkg;

  typedef enum logic [1:0] {OP_IDLE, OP_COUNT, OP_SPLIT, OP_RFSH} tree_op_e;

  // split threshold of a level; the last level uses the refresh threshold
  function automatic int unsigned lvl_thr(int unsigned lvl, int unsigned levels,
                                          int unsigned thr);
    return (lvl + 1 >= levels) ? thr : (thr * (lvl + 1)) / levels;
  endfunction

endpackage

// File: rtl/hot_row_match.sv
module hot_row_match #(
  parameter int unsigned ROW_W = 6
) (
  input  logic             busy_i,
  input  logic [ROW_W-1:0] lo_i,
  input  logic [ROW_W-1:0] hi_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             hit_o
);
  assign hit_o = busy_i && (row_i >= lo_i) && (row_i <= hi_i);
endmodule

// File: rtl/hot_row_free.sv
module hot_row_free #(
  parameter int unsigned NUM   = 6,
  parameter int unsigned IDX_W = 3
) (
  input  logic [NUM-1:0]   busy_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (!busy_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hot_row_clamp.sv
module hot_row_clamp #(
  parameter int unsigned ROW_W = 6
) (
  input  logic [ROW_W-1:0] lo_i,
  input  logic [ROW_W-1:0] hi_i,
  output logic [ROW_W-1:0] lo_o,
  output logic [ROW_W-1:0] hi_o
);
  assign lo_o = (lo_i == '0) ? '0 : lo_i - ROW_W'(1);
  assign hi_o = (hi_i == '1) ? '1 : hi_i + ROW_W'(1);
endmodule

// File: rtl/hot_row_tree.sv
module hot_row_tree
  import hot_row_pkg::*;
#(
  parameter int unsigned ROW_W    = 6,
  parameter int unsigned NUM_CTR  = 6,
  parameter int unsigned LEVELS   = 4,
  parameter int unsigned RFSH_THR = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             rfsh_o,
  output logic [ROW_W-1:0] rfsh_lo_o,
  output logic [ROW_W-1:0] rfsh_hi_o
);
  localparam int unsigned CNT_W = $clog2(RFSH_THR + 1);
  localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int unsigned IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam logic [CNT_W-1:0] THR_T = CNT_W'(RFSH_THR);

  logic [NUM_CTR-1:0] busy_q;
  logic [NUM_CTR-1:0] hit;
  logic [ROW_W-1:0]   lo_q  [NUM_CTR];
  logic [ROW_W-1:0]   hi_q  [NUM_CTR];
  logic [LVL_W-1:0]   lvl_q [NUM_CTR];
  logic [CNT_W-1:0]   cnt_q [NUM_CTR];
  logic [CNT_W-1:0]   thr_tab [LEVELS];

  logic [IDX_W-1:0] free_idx;
  logic             free_any;
  logic [ROW_W-1:0] sel_lo, sel_hi, half, clamp_lo, clamp_hi;
  logic [LVL_W-1:0] sel_lvl;
  logic [CNT_W-1:0] sel_cnt, cnt_nxt, sel_thr;
  logic             can_split;
  tree_op_e         op;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_match
    hot_row_match #(.ROW_W(ROW_W)) u_match (
      .busy_i (busy_q[g]),
      .lo_i   (lo_q[g]),
      .hi_i   (hi_q[g]),
      .row_i  (row_i),
      .hit_o  (hit[g])
    );
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_thr
    assign thr_tab[l] = CNT_W'(lvl_thr(l, LEVELS, RFSH_THR));
  end

  hot_row_free #(.NUM(NUM_CTR), .IDX_W(IDX_W)) u_free (
    .busy_i (busy_q),
    .idx_o  (free_idx),
    .any_o  (free_any)
  );

  // OR-mux of the single matching entry
  always_comb begin
    sel_lo  = '0;
    sel_hi  = '0;
    sel_lvl = '0;
    sel_cnt = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (hit[i]) begin
        sel_lo  |= lo_q[i];
        sel_hi  |= hi_q[i];
        sel_lvl |= lvl_q[i];
        sel_cnt |= cnt_q[i];
      end
    end
  end

  always_comb begin
    sel_thr = THR_T;
    for (int l = 0; l < LEVELS; l++) begin
      if (int'(sel_lvl) == l) sel_thr = thr_tab[l];
    end
  end

  assign cnt_nxt   = sel_cnt + CNT_W'(1);
  assign can_split = free_any && (int'(sel_lvl) < int'(LEVELS) - 1);
  assign half      = can_split ? (ROW_W'(1) << (int'(ROW_W) - 1 - int'(sel_lvl))) : '0;

  always_comb begin
    op = OP_IDLE;
    if (act_i && !start_i && (|hit)) begin
      if (cnt_nxt >= THR_T)                   op = OP_RFSH;
      else if (can_split && cnt_nxt >= sel_thr) op = OP_SPLIT;
      else                                    op = OP_COUNT;
    end
  end

  hot_row_clamp #(.ROW_W(ROW_W)) u_clamp (
    .lo_i (sel_lo),
    .hi_i (sel_hi),
    .lo_o (clamp_lo),
    .hi_o (clamp_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CTR; i++) begin
        busy_q[i] <= (i == 0);
        lo_q[i]   <= '0;
        hi_q[i]   <= (i == 0) ? '1 : '0;
        lvl_q[i]  <= '0;
        cnt_q[i]  <= '0;
      end
      rfsh_o    <= 1'b0;
      rfsh_lo_o <= '0;
      rfsh_hi_o <= '0;
    end else begin
      rfsh_o <= 1'b0;
      if (start_i) begin
        for (int i = 0; i < NUM_CTR; i++) begin
          busy_q[i] <= (i == 0);
          lo_q[i]   <= '0;
          hi_q[i]   <= (i == 0) ? '1 : '0;
          lvl_q[i]  <= '0;
          cnt_q[i]  <= '0;
        end
      end else begin
        for (int i = 0; i < NUM_CTR; i++) begin
          if (hit[i]) begin
            unique case (op)
              OP_COUNT: cnt_q[i] <= cnt_nxt;
              OP_RFSH:  cnt_q[i] <= '0;
              OP_SPLIT: begin
                cnt_q[i] <= cnt_nxt;
                hi_q[i]  <= sel_lo + half - ROW_W'(1);
                lvl_q[i] <= sel_lvl + LVL_W'(1);
              end
              default: ;
            endcase
          end
          if (op == OP_SPLIT && free_idx == IDX_W'(i)) begin
            busy_q[i] <= 1'b1;
            lo_q[i]   <= sel_lo + half;
            hi_q[i]   <= sel_hi;
            lvl_q[i]  <= sel_lvl + LVL_W'(1);
            cnt_q[i]  <= cnt_nxt;
          end
        end
        if (op == OP_RFSH) begin
          rfsh_o    <= 1'b1;
          rfsh_lo_o <= clamp_lo;
          rfsh_hi_o <= clamp_hi;
        end
      end
    end
  end

endmodule

// File: rtl/hot_row_tree_chk.sv
module hot_row_tree_chk #(
  parameter int unsigned ROW_W   = 6,
  parameter int unsigned NUM_CTR = 6,
  parameter int unsigned LEVELS  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               act_i,
  input logic [NUM_CTR-1:0] hit_i,
  input logic [NUM_CTR-1:0] busy_i,
  input logic               rfsh_i,
  input logic [ROW_W-1:0]   rfsh_lo_i,
  input logic [ROW_W-1:0]   rfsh_hi_i
);
  localparam int MIN_GRP = (2 ** ROW_W) >> (LEVELS - 1);

  AST_SINGLE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && !start_i) |-> $onehot(hit_i)); // R2

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ($onehot(busy_i) && busy_i[0] && !rfsh_i)); // R1

  AST_POOL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($countones(busy_i) >= $countones($past(busy_i))) &&
                 ($countones(busy_i) <= $countones($past(busy_i)) + 1)); // R3

  AST_RFSH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_i |-> ($past(act_i) && !$past(start_i))); // R5

  AST_RFSH_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_i |-> (rfsh_hi_i > rfsh_lo_i) &&
               (int'(rfsh_hi_i) - int'(rfsh_lo_i) >= MIN_GRP - 1)); // R7

  AST_RFSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_i && !act_i) |=> !rfsh_i); // R5
endmodule

bind hot_row_tree hot_row_tree_chk #(
  .ROW_W(ROW_W), .NUM_CTR(NUM_CTR), .LEVELS(LEVELS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .act_i     (act_i),
  .hit_i     (hit),
  .busy_i    (busy_q),
  .rfsh_i    (rfsh_o),
  .rfsh_lo_i (rfsh_lo_o),
  .rfsh_hi_i (rfsh_hi_o)
);

// File: tb/sim_hot_row_tree.sv
module sim_hot_row_tree;
  localparam int ROW_W = 6;
  localparam int NC    = 6;
  localparam int LV    = 4;
  localparam int T     = 16;
  localparam int N     = 2 ** ROW_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_r = 1'b0, act_r = 1'b0;
  logic [ROW_W-1:0] row_r = '0;
  logic rfsh;
  logic [ROW_W-1:0] rfsh_lo, rfsh_hi;

  int n_chk = 0, n_fail = 0;
  bit last_r; int last_lo, last_hi;

  int m_lo[NC], m_hi[NC], m_lvl[NC], m_cnt[NC];
  bit m_on[NC];

  always #2 clk = ~clk;

  hot_row_tree #(.ROW_W(ROW_W), .NUM_CTR(NC), .LEVELS(LV), .RFSH_THR(T)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_r), .act_i(act_r), .row_i(row_r),
    .rfsh_o(rfsh), .rfsh_lo_o(rfsh_lo), .rfsh_hi_o(rfsh_hi)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void m_init();
    for (int i = 0; i < NC; i++) begin
      m_on[i] = (i == 0); m_lo[i] = 0; m_hi[i] = (i == 0) ? N - 1 : 0;
      m_lvl[i] = 0; m_cnt[i] = 0;
    end
  endfunction

  function automatic void m_act(int row, output bit r, output int lo, output int hi);
    int k = -1, fr = -1, c, h;
    r = 0; lo = 0; hi = 0;
    for (int i = 0; i < NC; i++) if (m_on[i] && row >= m_lo[i] && row <= m_hi[i]) k = i;
    for (int i = NC - 1; i >= 0; i--) if (!m_on[i]) fr = i;
    if (k < 0) return;
    c = m_cnt[k] + 1;
    if (c == T) begin
      m_cnt[k] = 0; r = 1;
      lo = (m_lo[k] == 0) ? 0 : m_lo[k] - 1;
      hi = (m_hi[k] == N - 1) ? N - 1 : m_hi[k] + 1;
    end else if (fr >= 0 && m_lvl[k] < LV - 1 && c >= (T * (m_lvl[k] + 1)) / LV) begin
      h = (m_hi[k] - m_lo[k] + 1) / 2;
      m_on[fr] = 1; m_lo[fr] = m_lo[k] + h; m_hi[fr] = m_hi[k];
      m_lvl[fr] = m_lvl[k] + 1; m_cnt[fr] = c;
      m_hi[k] = m_lo[k] + h - 1; m_lvl[k]++; m_cnt[k] = c;
    end else m_cnt[k] = c;
  endfunction

  // one cycle; the design's registered outputs are compared with the model
  task automatic step(bit st, bit ac, int row);
    bit er; int el, eh;
    @(negedge clk);
    start_r = st; act_r = ac; row_r = row[ROW_W-1:0];
    @(posedge clk); #1;
    er = 0; el = 0; eh = 0;
    if (st) m_init();
    else if (ac) m_act(row, er, el, eh);
    last_r = rfsh; last_lo = int'(rfsh_lo); last_hi = int'(rfsh_hi);
    check(rfsh == er, "R5 refresh pulse vs model", int'(rfsh), int'(er));
    if (er) check(last_lo == el && last_hi == eh, "R6 refresh range vs model",
                  last_lo * 256 + last_hi, el * 256 + eh);
  endtask

  task automatic hammer(int row, int times);
    for (int i = 0; i < times; i++) step(0, 1, row);
  endtask

  task automatic expect_rf(string req, bit r, int lo, int hi);
    check(last_r == r, req, int'(last_r), int'(r));
    if (r) check(last_lo == lo && last_hi == hi, req, last_lo * 256 + last_hi, lo * 256 + hi);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    m_init();
    repeat (3) @(negedge clk);
    check(rfsh == 1'b0, "R1 no refresh in reset", int'(rfsh), 0);
    rst_n = 1'b1;

    // bottom edge: splits at 4, 8, 12; last level counts to T (R3, R7)
    step(1, 0, 0);
    hammer(0, 15);
    expect_rf("R3 no refresh before T", 0, 0, 0);
    hammer(0, 1);
    expect_rf("R6 bottom clamp 0..8", 1, 0, 8);

    step(1, 0, 0);
    hammer(63, 16);
    expect_rf("R6 top clamp 55..63", 1, 55, 63);

    step(1, 0, 0);
    hammer(20, 16);
    expect_rf("R7 mid group 15..24", 1, 15, 24);

    // start wins over a same-cycle activate
    step(1, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 1, 5);
    hammer(5, 15);
    expect_rf("R1 activates with start ignored", 0, 0, 0);
    hammer(5, 1);
    expect_rf("R1 count from zero after start", 1, 0, 8);

    // fill the pool while rows 48..63 still sit at level 2
    step(1, 0, 0);
    hammer(0, 12);
    hammer(16, 4);
    hammer(48, 4);
    hammer(48, 7);
    expect_rf("R4 full pool no split", 0, 0, 0);
    hammer(48, 1);
    expect_rf("R4 full pool refresh 47..63", 1, 47, 63);

    // biased random traffic against the model (R2)
    step(1, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int sel, row, hot;
      hot = (i / 700) * 9 % N;
      sel = int'($urandom_range(0, 99));
      if (i % 500 == 499) step(1, 0, 0);
      else if (sel < 10) step(0, 0, 0);
      else if (sel < 70) begin
        row = (hot + int'($urandom_range(0, 3))) % N;
        step(0, 1, row);
      end else begin
        row = int'($urandom_range(0, N - 1));
        step(0, 1, row);
      end
    end

    summary();
    $finish;
  end
endmodule